// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This combinational block decides where execution goes after the current instruction. It takes the 32-bit instruction word, the current program counter and the values of the two source registers. For a conditional branch it rebuilds the scattered 13-bit offset from the instruction and evaluates the compare that `funct3` selects, signed or unsigned. For the direct jump it rebuilds the scattered 21-bit offset. For the register-indirect jump it adds a 12-bit immediate to the first operand. Every other instruction advances the counter by four.

The outputs are the next program counter and a flag that marks a non-sequential transfer, so a fetch stage can drop the instruction it fetched in sequence. There is also a link-write request with its destination index and the return address. The return address is always formed from the counter value presented at the input. A jump whose base register is also its destination therefore still links to the correct place. All counter arithmetic wraps modulo 2^32.

Top module: `npc_unit`

## Requirements
- R1: For any opcode (inst[6:0]) other than 0x63, 0x6F and 0x67, next_pc equals pc+4, taken is 0 and link_we is 0.
- R2: For opcode 0x63 the offset is the 13-bit two's-complement value {inst[31], inst[7], inst[30:25], inst[11:8], 0}. A taken branch sets next_pc to pc plus that offset, sign-extended.
- R3: With opcode 0x63, funct3 (inst[14:12]) = 0 takes the branch when rs1 equals rs2, and funct3 = 1 takes it when they differ.
- R4: With opcode 0x63, funct3 = 4 takes the branch when rs1 < rs2 as signed 32-bit numbers, and funct3 = 5 takes it when rs1 >= rs2 as signed numbers.
- R5: With opcode 0x63, funct3 = 6 takes the branch when rs1 < rs2 as unsigned numbers, and funct3 = 7 takes it when rs1 >= rs2 as unsigned numbers.
- R6: With opcode 0x63, funct3 = 2 or 3 never takes the branch: next_pc is pc+4 and taken is 0.
- R7: Opcode 0x6F always transfers to pc plus the 21-bit two's-complement offset {inst[31], inst[19:12], inst[20], inst[30:21], 0}. It sets taken and requests a link write of pc+4 into rd (inst[11:7]).
- R8: Opcode 0x67 with funct3 = 0 transfers to rs1 plus the sign-extended inst[31:20], sets taken and links pc+4. With funct3 other than 0 it behaves as in R1.
- R9: When rd = 0 a jump still transfers but link_we is 0. link_val equals pc+4 and never depends on rs1, even when the rs1 index equals rd.
- R10: All sums wrap modulo 2^32: the sequential step, branch targets and both jump targets.
- R11: A conditional branch, taken or not, never requests a link write. A branch that is not taken leaves taken at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst_i | input | 32 | Instruction word under execution |
| pc_i | input | 32 | Address of that instruction |
| rs1_val_i | input | 32 | Value of the first source register |
| rs2_val_i | input | 32 | Value of the second source register |
| next_pc_o | output | 32 | Address of the next instruction |
| taken_o | output | 1 | High for a taken branch or any jump |
| link_we_o | output | 1 | Request to write the return address |
| link_rd_o | output | 5 | Destination register index inst[11:7] |
| link_val_o | output | 32 | Return address, pc+4 |

## Verification
The block holds no state, so a fault in the offset unpacking, the compare selection or the target adders shows at next_pc_o in the same evaluation as the input that triggers it. There is no delay before the error appears. A bit routed from the wrong place in the unpacking only appears when that bit of the offset is set. For this reason the sweep uses offsets at both signed extremes as well as small ones. A signed/unsigned mix-up only shows when the operands' sign bits differ, so the operand set pairs values across the sign boundary.

// File: rtl/npc_pkg.sv
package npc_pkg;

   localparam int unsigned INST_W   = 32;
   localparam int unsigned RIDX_W   = 5;
   localparam int unsigned OPC_W    = 7;
   localparam int unsigned F3_W     = 3;

   localparam logic [OPC_W-1:0] OPC_COND_BR  = 7'h63;
   localparam logic [OPC_W-1:0] OPC_DIR_JMP  = 7'h6F;
   localparam logic [OPC_W-1:0] OPC_IND_JMP  = 7'h67;

   typedef enum logic [F3_W-1:0] {
      CMP_EQ   = 3'd0,
      CMP_NE   = 3'd1,
      CMP_RSV2 = 3'd2,
      CMP_RSV3 = 3'd3,
      CMP_LT   = 3'd4,
      CMP_GE   = 3'd5,
      CMP_LTU  = 3'd6,
      CMP_GEU  = 3'd7
   } cmp_sel_e;

   typedef enum logic [1:0] {
      XFER_NONE   = 2'd0,
      XFER_BRANCH = 2'd1,
      XFER_DIRECT = 2'd2,
      XFER_INDIR  = 2'd3
   } xfer_kind_e;

   typedef struct packed {
      xfer_kind_e          kind;
      cmp_sel_e            cond;
      logic [RIDX_W-1:0]   rd;
   } xfer_decode_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
(
   input  logic [OPC_W-1:0]  opcode_i,
   input  logic [F3_W-1:0]   funct3_i,
   input  logic [RIDX_W-1:0] rd_i,
   output xfer_decode_t      dec_o
);

   xfer_kind_e kind;

   always_comb begin
      unique case (opcode_i)
         OPC_COND_BR: kind = XFER_BRANCH;
         OPC_DIR_JMP: kind = XFER_DIRECT;
         OPC_IND_JMP: kind = (funct3_i == '0) ? XFER_INDIR : XFER_NONE;
         default:     kind = XFER_NONE;
      endcase
   end

   assign dec_o.kind = kind;
   assign dec_o.cond = cmp_sel_e'(funct3_i);
   assign dec_o.rd   = rd_i;

   // R8: an indirect-jump opcode with nonzero funct3 must fall back to sequential
   always_comb begin
      if (opcode_i == OPC_IND_JMP && funct3_i != '0)
         assert_indir_f3_R8: assert (kind == XFER_NONE);
   end

endmodule

// File: rtl/npc_imm_unpack.sv
module npc_imm_unpack
   import npc_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [INST_W-1:7] ifield_i,
   output logic [XLEN-1:0]   br_off_o,
   output logic [XLEN-1:0]   jmp_off_o,
   output logic [XLEN-1:0]   ind_imm_o
);

   localparam int unsigned BR_W  = 13;
   localparam int unsigned JMP_W = 21;
   localparam int unsigned IND_W = 12;

   generate
      if (XLEN < JMP_W) begin : g_bad_xlen
         $error("npc_imm_unpack: XLEN must hold the widest offset");
      end
   endgenerate

   logic [BR_W-1:0]  br_raw;
   logic [JMP_W-1:0] jmp_raw;
   logic [IND_W-1:0] ind_raw;

   // Conditional-branch offset: bits gathered from both ends of the word
   assign br_raw  = {ifield_i[31], ifield_i[7], ifield_i[30:25],
                     ifield_i[11:8], 1'b0};
   // Direct-jump offset: upper middle field sits below the split low field
   assign jmp_raw = {ifield_i[31], ifield_i[19:12], ifield_i[20],
                     ifield_i[30:21], 1'b0};
   // Indirect-jump immediate is contiguous
   assign ind_raw = ifield_i[31:20];

   assign br_off_o  = {{(XLEN-BR_W){br_raw[BR_W-1]}},   br_raw};
   assign jmp_off_o = {{(XLEN-JMP_W){jmp_raw[JMP_W-1]}}, jmp_raw};
   assign ind_imm_o = {{(XLEN-IND_W){ind_raw[IND_W-1]}}, ind_raw};

   always_comb begin
      assert_br_even_R2: assert (br_off_o[0] == 1'b0);
      assert_jmp_even_R7: assert (jmp_off_o[0] == 1'b0);
      assert_br_sign_R2: assert (br_off_o[XLEN-1] == ifield_i[31]);
      assert_ind_sign_R8: assert (ind_imm_o[XLEN-1] == ifield_i[31]);
   end

endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
   import npc_pkg::*;
#(
   parameter int unsigned XLEN           = 32,
   parameter bit          USE_SHARED_SUB = 1'b1
) (
   input  cmp_sel_e         sel_i,
   input  logic [XLEN-1:0]  a_i,
   input  logic [XLEN-1:0]  b_i,
   output logic             hit_o
);

   localparam int unsigned MSB = XLEN - 1;

   generate
      if (XLEN < 2) begin : g_bad_xlen
         $error("npc_cond_eval: XLEN too small");
      end
   endgenerate

   logic as_signed;
   logic is_eq;
   logic is_lt;

   assign as_signed = (sel_i == CMP_LT) || (sel_i == CMP_GE);

   generate
      if (USE_SHARED_SUB) begin : g_shared_sub
         // One XLEN+1 subtractor serves equality and both orderings
         logic [XLEN:0] diff;
         logic          ext_a;
         logic          ext_b;
         assign ext_a = as_signed & a_i[MSB];
         assign ext_b = as_signed & b_i[MSB];
         assign diff  = {ext_a, a_i} - {ext_b, b_i};
         assign is_lt = diff[XLEN];
         assign is_eq = ~|diff[XLEN-1:0];
      end else begin : g_native_cmp
         // Separate comparators: shallower, more area
         logic lt_s;
         logic lt_u;
         assign lt_s  = $signed(a_i) < $signed(b_i);
         assign lt_u  = a_i < b_i;
         assign is_lt = as_signed ? lt_s : lt_u;
         assign is_eq = (a_i == b_i);
      end
   endgenerate

   always_comb begin
      unique case (sel_i)
         CMP_EQ:           hit_o = is_eq;
         CMP_NE:           hit_o = ~is_eq;
         CMP_LT, CMP_LTU:  hit_o = is_lt;
         CMP_GE, CMP_GEU:  hit_o = ~is_lt;
         default:          hit_o = 1'b0;
      endcase
   end

   // When signs differ the verdict is fixed by the sign bits alone
   always_comb begin
      if (sel_i == CMP_LT && a_i[MSB] != b_i[MSB])
         assert_signed_split_R4: assert (hit_o == a_i[MSB]);
      if (sel_i == CMP_LTU && a_i[MSB] != b_i[MSB])
         assert_unsigned_split_R5: assert (hit_o == b_i[MSB]);
      if (sel_i == CMP_RSV2 || sel_i == CMP_RSV3)
         assert_reserved_never_R6: assert (!hit_o);
      if (sel_i == CMP_EQ && a_i == b_i)
         assert_eq_hit_R3: assert (hit_o);
   end

endmodule

// File: rtl/npc_target_sel.sv
module npc_target_sel
   import npc_pkg::*;
#(
   parameter int unsigned XLEN            = 32,
   parameter int unsigned STEP            = 4,
   parameter bit          SHARE_PC_ADDER  = 1'b1
) (
   input  xfer_kind_e       kind_i,
   input  logic             cond_hit_i,
   input  logic [XLEN-1:0]  pc_i,
   input  logic [XLEN-1:0]  rs1_i,
   input  logic [XLEN-1:0]  br_off_i,
   input  logic [XLEN-1:0]  jmp_off_i,
   input  logic [XLEN-1:0]  ind_imm_i,
   output logic [XLEN-1:0]  next_pc_o,
   output logic [XLEN-1:0]  seq_pc_o,
   output logic             taken_o
);

   localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

   generate
      if (STEP == 0) begin : g_bad_step
         $error("npc_target_sel: STEP must be nonzero");
      end
   endgenerate

   logic [XLEN-1:0] xfer_tgt;

   assign seq_pc_o = pc_i + STEP_V;

   generate
      if (SHARE_PC_ADDER) begin : g_one_adder
         // Mux base and offset first, then one adder for all transfers
         logic [XLEN-1:0] base;
         logic [XLEN-1:0] offs;
         always_comb begin
            unique case (kind_i)
               XFER_DIRECT: begin base = pc_i;  offs = jmp_off_i; end
               XFER_INDIR:  begin base = rs1_i; offs = ind_imm_i; end
               default:     begin base = pc_i;  offs = br_off_i;  end
            endcase
         end
         assign xfer_tgt = base + offs;
      end else begin : g_three_adders
         // Each target computed in parallel, selection after the adders
         logic [XLEN-1:0] br_tgt;
         logic [XLEN-1:0] dir_tgt;
         logic [XLEN-1:0] ind_tgt;
         assign br_tgt  = pc_i + br_off_i;
         assign dir_tgt = pc_i + jmp_off_i;
         assign ind_tgt = rs1_i + ind_imm_i;
         always_comb begin
            unique case (kind_i)
               XFER_DIRECT: xfer_tgt = dir_tgt;
               XFER_INDIR:  xfer_tgt = ind_tgt;
               default:     xfer_tgt = br_tgt;
            endcase
         end
      end
   endgenerate

   always_comb begin
      unique case (kind_i)
         XFER_BRANCH:            taken_o = cond_hit_i;
         XFER_DIRECT, XFER_INDIR: taken_o = 1'b1;
         default:                taken_o = 1'b0;
      endcase
   end

   assign next_pc_o = taken_o ? xfer_tgt : seq_pc_o;

   always_comb begin
      if (kind_i == XFER_NONE)
         assert_none_not_taken_R1: assert (!taken_o);
      if (kind_i == XFER_INDIR)
         assert_indir_target_R8: assert (next_pc_o == rs1_i + ind_imm_i);
   end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int unsigned XLEN           = 32,
   parameter int unsigned LINK_STEP      = 4,
   parameter bit          USE_SHARED_SUB = 1'b1,
   parameter bit          SHARE_PC_ADDER = 1'b1
) (
   input  logic [INST_W-1:0]  inst_i,
   input  logic [XLEN-1:0]    pc_i,
   input  logic [XLEN-1:0]    rs1_val_i,
   input  logic [XLEN-1:0]    rs2_val_i,
   output logic [XLEN-1:0]    next_pc_o,
   output logic               taken_o,
   output logic               link_we_o,
   output logic [RIDX_W-1:0]  link_rd_o,
   output logic [XLEN-1:0]    link_val_o
);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("npc_unit: the instruction set fixes XLEN at 32");
      end
      if (LINK_STEP != 4) begin : g_bad_step
         $error("npc_unit: instructions are four bytes wide");
      end
   endgenerate

   xfer_decode_t     dec;
   logic [XLEN-1:0]  br_off;
   logic [XLEN-1:0]  jmp_off;
   logic [XLEN-1:0]  ind_imm;
   logic             cond_hit;
   logic [XLEN-1:0]  seq_pc;

   npc_decode u_decode (
      .opcode_i (inst_i[6:0]),
      .funct3_i (inst_i[14:12]),
      .rd_i     (inst_i[11:7]),
      .dec_o    (dec)
   );

   npc_imm_unpack #(.XLEN(XLEN)) u_imm (
      .ifield_i  (inst_i[INST_W-1:7]),
      .br_off_o  (br_off),
      .jmp_off_o (jmp_off),
      .ind_imm_o (ind_imm)
   );

   npc_cond_eval #(
      .XLEN           (XLEN),
      .USE_SHARED_SUB (USE_SHARED_SUB)
   ) u_cond (
      .sel_i (dec.cond),
      .a_i   (rs1_val_i),
      .b_i   (rs2_val_i),
      .hit_o (cond_hit)
   );

   npc_target_sel #(
      .XLEN           (XLEN),
      .STEP           (LINK_STEP),
      .SHARE_PC_ADDER (SHARE_PC_ADDER)
   ) u_tgt (
      .kind_i     (dec.kind),
      .cond_hit_i (cond_hit),
      .pc_i       (pc_i),
      .rs1_i      (rs1_val_i),
      .br_off_i   (br_off),
      .jmp_off_i  (jmp_off),
      .ind_imm_i  (ind_imm),
      .next_pc_o  (next_pc_o),
      .seq_pc_o   (seq_pc),
      .taken_o    (taken_o)
   );

   logic is_jump;
   assign is_jump    = (dec.kind == XFER_DIRECT) || (dec.kind == XFER_INDIR);
   assign link_we_o  = is_jump && (dec.rd != '0);
   assign link_rd_o  = dec.rd;
   assign link_val_o = seq_pc;

   always_comb begin
      if (!taken_o)
         assert_seq_when_idle_R1: assert (next_pc_o == pc_i + XLEN'(LINK_STEP));
      if (link_we_o)
         assert_link_is_jump_R7: assert (taken_o);
      if (link_we_o)
         assert_link_nonzero_rd_R9: assert (link_rd_o != '0);
      assert_link_old_pc_R9: assert (link_val_o == pc_i + XLEN'(LINK_STEP));
      if (inst_i[6:0] == OPC_COND_BR)
         assert_branch_no_link_R11: assert (!link_we_o);
   end

endmodule

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;

   logic        clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [31:0] inst;
   logic [31:0] pc;
   logic [31:0] rs1v;
   logic [31:0] rs2v;
   logic [31:0] next_pc;
   logic        taken;
   logic        link_we;
   logic [4:0]  link_rd;
   logic [31:0] link_val;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   npc_unit u0 (
      .inst_i     (inst),
      .pc_i       (pc),
      .rs1_val_i  (rs1v),
      .rs2_val_i  (rs2v),
      .next_pc_o  (next_pc),
      .taken_o    (taken),
      .link_we_o  (link_we),
      .link_rd_o  (link_rd),
      .link_val_o (link_val)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic [31:0] i, input logic [31:0] p,
                        input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      inst = i; pc = p; rs1v = a; rs2v = b;
      #1;
   endtask

   function automatic logic [31:0] enc_br(input logic [2:0] f3,
                                          input logic [12:0] off);
      return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'h63};
   endfunction

   function automatic logic [31:0] enc_jal(input logic [4:0] rd,
                                           input logic [20:0] off);
      return {off[20], off[10:1], off[11], off[19:12], rd, 7'h6F};
   endfunction

   function automatic logic [31:0] enc_jalr(input logic [4:0] rd,
                                            input logic [4:0] rs,
                                            input logic [2:0] f3,
                                            input logic [11:0] imm);
      return {imm, rs, f3, rd, 7'h67};
   endfunction

   function automatic logic br_cond(input logic [2:0] f3,
                                    input logic [31:0] a, input logic [31:0] b);
      case (f3)
         3'd0: return a == b;
         3'd1: return a != b;
         3'd4: return $signed(a) <  $signed(b);
         3'd5: return $signed(a) >= $signed(b);
         3'd6: return a <  b;
         3'd7: return a >= b;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string f3_tag(input logic [2:0] f3);
      case (f3)
         3'd0, 3'd1: return "R3";
         3'd4, 3'd5: return "R4";
         3'd6, 3'd7: return "R5";
         default:    return "R6";
      endcase
   endfunction

   logic [31:0] opnd [6];
   logic [12:0] boff [4];
   logic [20:0] joff [5];
   logic [11:0] iimm [5];
   logic [4:0]  rds  [3];

   initial begin
      opnd[0] = 32'h0000_0000; opnd[1] = 32'h0000_0001;
      opnd[2] = 32'h7FFF_FFFF; opnd[3] = 32'h8000_0000;
      opnd[4] = 32'hFFFF_FFFF; opnd[5] = 32'h1234_5678;
      boff[0] = 13'h0008; boff[1] = 13'h1FFC;
      boff[2] = 13'h0FFE; boff[3] = 13'h1000;
      joff[0] = 21'h00004; joff[1] = 21'h1FFFFC; joff[2] = 21'h0FFFFE;
      joff[3] = 21'h100000; joff[4] = 21'h12346;
      iimm[0] = 12'h000; iimm[1] = 12'h001; iimm[2] = 12'h7FF;
      iimm[3] = 12'hFFF; iimm[4] = 12'h800;
      rds[0] = 5'd0; rds[1] = 5'd1; rds[2] = 5'd31;

      inst = '0; pc = 32'h0000_1000; rs1v = '0; rs2v = '0;

      // Initial state: an all-zero word is not a control transfer (R1)
      drive(32'h0, 32'h0000_1000, 32'h0, 32'h0);
      chk("R1", "initial next_pc", next_pc, 32'h0000_1004);
      chk("R1", "initial taken", {31'b0, taken}, 32'h0);
      chk("R1", "initial link_we", {31'b0, link_we}, 32'h0);

      // R1: every other opcode advances by four
      for (int op = 0; op < 128; op++) begin
         if (op == 'h63 || op == 'h6F || op == 'h67) continue;
         drive({25'h1ABCDEF ^ 25'(op * 7919), op[6:0]}, 32'h0040_0000 + 32'(op * 4),
               32'hDEAD_BEEF, 32'h0BAD_F00D);
         chk("R1", "seq next_pc", next_pc, 32'h0040_0004 + 32'(op * 4));
         chk("R1", "seq taken", {31'b0, taken}, 32'h0);
         chk("R1", "seq link_we", {31'b0, link_we}, 32'h0);
      end

      // R2..R6, R11: branch sweep over conditions, operands and offsets
      for (int f = 0; f < 8; f++) begin
         for (int ia = 0; ia < 6; ia++) begin
            for (int ib = 0; ib < 6; ib++) begin
               for (int io = 0; io < 4; io++) begin
                  logic [31:0] p;
                  logic        c;
                  logic [31:0] exp_pc;
                  p = 32'h2000_0000 + 32'(io * 256);
                  c = br_cond(f[2:0], opnd[ia], opnd[ib]);
                  exp_pc = c ? p + {{19{boff[io][12]}}, boff[io]} : p + 32'd4;
                  drive(enc_br(f[2:0], boff[io]), p, opnd[ia], opnd[ib]);
                  chk(f3_tag(f[2:0]), "branch taken", {31'b0, taken}, {31'b0, c});
                  chk("R2", "branch next_pc", next_pc, exp_pc);
                  chk("R11", "branch link_we", {31'b0, link_we}, 32'h0);
               end
            end
         end
      end

      // R7: direct jump over offsets and destinations
      for (int io = 0; io < 5; io++) begin
         for (int ir = 0; ir < 3; ir++) begin
            logic [31:0] p;
            p = 32'h3000_0000 + 32'(io * 64);
            drive(enc_jal(rds[ir], joff[io]), p, 32'h5555_5555, 32'h0);
            chk("R7", "jal next_pc", next_pc, p + {{11{joff[io][20]}}, joff[io]});
            chk("R7", "jal taken", {31'b0, taken}, 32'h1);
            chk("R7", "jal link_val", link_val, p + 32'd4);
            chk("R7", "jal link_rd", {27'b0, link_rd}, {27'b0, rds[ir]});
            chk("R9", "jal link_we", {31'b0, link_we}, {31'b0, rds[ir] != 5'd0});
         end
      end

      // R8: indirect jump over immediates, bases and destinations
      for (int ii = 0; ii < 5; ii++) begin
         for (int ib = 2; ib < 5; ib++) begin
            for (int ir = 0; ir < 3; ir++) begin
               logic [31:0] p;
               p = 32'h4000_0010;
               drive(enc_jalr(rds[ir], 5'd3, 3'd0, iimm[ii]), p, opnd[ib], 32'h0);
               chk("R8", "jalr next_pc", next_pc,
                   opnd[ib] + {{20{iimm[ii][11]}}, iimm[ii]});
               chk("R8", "jalr taken", {31'b0, taken}, 32'h1);
               chk("R8", "jalr link_val", link_val, p + 32'd4);
               chk("R9", "jalr link_we", {31'b0, link_we}, {31'b0, rds[ir] != 5'd0});
            end
         end
         // R8: nonzero funct3 is not a jump
         for (int f = 1; f < 8; f++) begin
            drive(enc_jalr(5'd7, 5'd3, f[2:0], iimm[ii]), 32'h4000_0100, 32'h9000_0000, 32'h0);
            chk("R8", "jalr bad f3 next_pc", next_pc, 32'h4000_0104);
            chk("R8", "jalr bad f3 taken", {31'b0, taken}, 32'h0);
            chk("R8", "jalr bad f3 link_we", {31'b0, link_we}, 32'h0);
         end
      end

      // R9: base register equals destination; link from pc, not rs1
      drive(enc_jalr(5'd5, 5'd5, 3'd0, 12'h010), 32'h0000_8000, 32'hABCD_0000, 32'h0);
      chk("R9", "rs1==rd link_val", link_val, 32'h0000_8004);
      chk("R9", "rs1==rd next_pc", next_pc, 32'hABCD_0010);
      chk("R9", "rs1==rd link_we", {31'b0, link_we}, 32'h1);

      // R10: wrap-around cases
      drive(32'h0000_0013, 32'hFFFF_FFFC, 32'h0, 32'h0);
      chk("R10", "seq wrap", next_pc, 32'h0000_0000);
      drive(enc_br(3'd0, 13'h1FFC), 32'h0000_0000, 32'h7, 32'h7);
      chk("R10", "branch wrap down", next_pc, 32'hFFFF_FFFC);
      drive(enc_jal(5'd1, 21'h00020), 32'hFFFF_FFF0, 32'h0, 32'h0);
      chk("R10", "jal wrap up", next_pc, 32'h0000_0010);
      chk("R10", "jal link wrap", link_val, 32'hFFFF_FFF4);
      drive(enc_jalr(5'd1, 5'd2, 3'd0, 12'h7FF), 32'h0, 32'hFFFF_FF00, 32'h0);
      chk("R10", "jalr wrap up", next_pc, 32'h0000_06FF);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++;
         checks++;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule